// File: doc/BRIEF.md
# Count Input Front End

This block sits between three raw pins and a counter core. It turns them into single-cycle count-up and count-down strobes in the system clock domain. Two of the pins, A and B, carry count information. The third, the G pin, acts either as a counting gate or as a request to clear the counter. Each pin passes through a two-flop synchronizer. Events are then found by comparing each synchronized level with its value one cycle earlier.

The count pins have three interpretations:

- **Separate pins:** one pin counts up and the other counts down.
- **Count and direction:** one pin carries the count and the other sets its direction.
- **Quadrature:** the pins are decoded at x1, x2 or x4 resolution.

Quadrature, when selected, takes precedence over the non-quadrature choice. A direction status bit reports the direction of the last legal quadrature transition. Software can also inject one-cycle single-step commands, which bypass the enable and the gate.

Top module: `count_front_end`

## Requirements
- R1: With `quad_sel` = 0 and `dir_mode` = 0, a rising edge on `pin_a` yields one `cnt_up` pulse and a rising edge on `pin_b` yields one `cnt_dn` pulse. A pin change made before clock edge k is seen in the cycle after edge k+1.
- R2: With `quad_sel` = 0 and `dir_mode` = 1, a rising edge on `pin_a` counts up when `pin_b` is 0 and counts down when `pin_b` is 1. Changes on `pin_b` alone never count.
- R3: `quad_sel` = 3 (x4) counts every single-pin transition. The sequence 00→10→11→01→00, written as (A,B), counts up, and the reverse sequence counts down.
- R4: `quad_sel` = 2 (x2) counts only the transitions in which A changes, with the same direction rule as R3.
- R5: `quad_sel` = 1 (x1) counts only rising edges of A: up when B is 0 and down when B is 1.
- R6: In any quadrature mode, a transition in which A and B change in the same sample produces no count.
- R7: While `in_enable` is 0, pin events produce no strobes.
- R8: With `g_is_gate` = 1, a high level on `pin_g` blocks pin counting and a low level allows it.
- R9: With `g_is_gate` = 0, `ctr_clear` equals the inverse of the synchronized `pin_g`. With `g_is_gate` = 1, `ctr_clear` is 0.
- R10: `step_up` and `step_dn` produce `cnt_up` and `cnt_dn` in the same cycle, whatever `in_enable` and `pin_g` are.
- R11: `cnt_up` and `cnt_dn` are never high together. Coinciding up and down requests cancel each other.
- R12: In quadrature mode, `dir_up` holds 1 after an up transition and 0 after a down transition. When `quad_sel` = 0 it reads 1.
- R13: During and right after reset, no strobes are produced and `dir_up` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Raw count pin A |
| pin_b | input | 1 | Raw count pin B |
| pin_g | input | 1 | Raw gate or clear pin, active low |
| in_enable | input | 1 | Enables counting from the pins |
| dir_mode | input | 1 | 0: separate up/down pins, 1: count plus direction |
| quad_sel | input | 2 | 0 off, 1 x1, 2 x2, 3 x4 |
| g_is_gate | input | 1 | 1: `pin_g` gates counting, 0: `pin_g` requests clear |
| step_up | input | 1 | Single-step increment command |
| step_dn | input | 1 | Single-step decrement command |
| cnt_up | output | 1 | One-cycle count-up strobe |
| cnt_dn | output | 1 | One-cycle count-down strobe |
| ctr_clear | output | 1 | Counter clear request |
| dir_up | output | 1 | Quadrature direction status |

## Verification
Several rules are checked by assertions on every cycle:

- the up and down strobes never coincide;
- the direction bit is held at 1 outside quadrature;
- a disabled block with no step command stays silent;
- a double-pin quadrature change never produces an event;
- the clear request never appears in gate mode.

Other behaviour can only be shown by the bench's scenarios. This covers whether each mode counts the correct edges in the correct direction, the two-edge latency, the effect of the gate, and how the direction bit follows forward and reverse motion.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef enum logic [1:0] {
    QM_OFF = 2'd0,
    QM_X1  = 2'd1,
    QM_X2  = 2'd2,
    QM_X4  = 2'd3
  } quad_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;

  // Quadrature decode on one sample step: current (a,b) vs previous (ap,bp)
  function automatic step_t quad_decode(quad_mode_e m, logic a, logic b,
                                        logic ap, logic bp);
    step_t r;
    logic  ach, bch, fwd;
    r   = '0;
    ach = a ^ ap;
    bch = b ^ bp;
    // A leading B is the forward direction
    fwd = ach ? (a ^ b) : ~(a ^ b);
    if (ach ^ bch) begin
      case (m)
        QM_X4: begin r.up = fwd; r.dn = ~fwd; end
        QM_X2: if (ach) begin r.up = fwd; r.dn = ~fwd; end
        QM_X1: if (ach && a) begin r.up = ~b; r.dn = b; end
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  // Non-quadrature decode: separate pins or count plus direction
  function automatic step_t plain_decode(logic dm, logic a, logic b,
                                         logic ap, logic bp);
    step_t r;
    logic  rise_a, rise_b;
    rise_a = a & ~ap;
    rise_b = b & ~bp;
    if (!dm) begin
      r.up = rise_a;
      r.dn = rise_b;
    end else begin
      r.up = rise_a & ~b;
      r.dn = rise_a & b;
    end
    return r;
  endfunction
endpackage

// File: rtl/cfe_sync.sv
module cfe_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  localparam int CW = STAGES * W;

  logic [CW-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= {STAGES{RST}};
      q_prev <= RST;
    end else begin
      chain  <= {chain[CW-W-1:0], d};
      q_prev <= chain[CW-1 -: W];
    end
  end

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/cfe_decode.sv
module cfe_decode
  import cfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  quad_mode_e qmode,
  input  logic       dir_mode,
  input  logic       a,
  input  logic       b,
  input  logic       ap,
  input  logic       bp,
  output logic       ev_up,
  output logic       ev_dn,
  output logic       dir_up
);
  step_t qs, ps, dirstep, sel;
  logic  a_ch, b_ch, dir_q;

  assign a_ch    = a ^ ap;
  assign b_ch    = b ^ bp;
  assign qs      = quad_decode(qmode, a, b, ap, bp);
  assign ps      = plain_decode(dir_mode, a, b, ap, bp);
  assign dirstep = quad_decode(QM_X4, a, b, ap, bp);
  assign sel     = (qmode == QM_OFF) ? ps : qs;
  assign ev_up   = sel.up;
  assign ev_dn   = sel.dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dir_q <= 1'b1;
    else if (dirstep.up)       dir_q <= 1'b1;
    else if (dirstep.dn)       dir_q <= 1'b0;
  end

  assign dir_up = (qmode == QM_OFF) ? 1'b1 : dir_q;

  // R6: simultaneous change of both pins never yields an event in quadrature
  p_illegal_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (qmode != QM_OFF && a_ch && b_ch) |-> !(ev_up || ev_dn));

  // R12: direction bit held high when quadrature is off
  p_dir_forced_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (qmode == QM_OFF) |-> dir_up);
endmodule

// File: rtl/count_front_end.sv
module count_front_end
  import cfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       pin_g,
  input  logic       in_enable,
  input  logic       dir_mode,
  input  logic [1:0] quad_sel,
  input  logic       g_is_gate,
  input  logic       step_up,
  input  logic       step_dn,
  output logic       cnt_up,
  output logic       cnt_dn,
  output logic       ctr_clear,
  output logic       dir_up
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b100; // G idles high, A/B low

  logic [NPIN-1:0] s_cur, s_prev;
  logic            ev_up, ev_dn, gate_ok, req_up, req_dn;

  cfe_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST(PIN_RST)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({pin_g, pin_b, pin_a}),
    .q      (s_cur),
    .q_prev (s_prev)
  );

  cfe_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .qmode    (quad_mode_e'(quad_sel)),
    .dir_mode (dir_mode),
    .a        (s_cur[0]),
    .b        (s_cur[1]),
    .ap       (s_prev[0]),
    .bp       (s_prev[1]),
    .ev_up    (ev_up),
    .ev_dn    (ev_dn),
    .dir_up   (dir_up)
  );

  assign gate_ok   = in_enable && !(g_is_gate && s_cur[2]);
  assign req_up    = (ev_up && gate_ok) || step_up;
  assign req_dn    = (ev_dn && gate_ok) || step_dn;
  assign cnt_up    = req_up && !req_dn;
  assign cnt_dn    = req_dn && !req_up;
  assign ctr_clear = !g_is_gate && !s_cur[2];

  // R11: strobes are mutually exclusive
  p_excl_strobes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn));

  // R7: disabled with no step command means silence
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_enable && !step_up && !step_dn) |-> (!cnt_up && !cnt_dn));

  // R9: no clear request while the pin acts as a gate
  p_clear_only_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    g_is_gate |-> !ctr_clear);

  // R10: a lone step command always reaches the output
  p_step_passes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_dn && !(ev_dn && gate_ok)) |-> cnt_up);
endmodule

// File: tb/sim_count_front_end.sv
`timescale 1ns/1ps
module sim_count_front_end;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, pin_g = 1'b0;
  logic in_enable = 1'b1, dir_mode = 1'b0, g_is_gate = 1'b1;
  logic step_up = 1'b0, step_dn = 1'b0;
  logic [1:0] quad_sel = 2'd0;
  logic cnt_up, cnt_dn, ctr_clear, dir_up;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  count_front_end u0 (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_g(pin_g),
    .in_enable(in_enable), .dir_mode(dir_mode), .quad_sel(quad_sel),
    .g_is_gate(g_is_gate), .step_up(step_up), .step_dn(step_dn),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .ctr_clear(ctr_clear), .dir_up(dir_up)
  );

  // {quad_sel[1:0], dir_mode, a, b, exp_up, exp_dn}
  localparam int NV = 29;
  localparam logic [6:0] VEC [NV] = '{
    // R1 separate pins
    7'b00_0_10_10, 7'b00_0_00_00, 7'b00_0_01_01, 7'b00_0_00_00,
    // R2 count plus direction
    7'b00_1_10_10, 7'b00_1_00_00, 7'b00_1_01_00, 7'b00_1_11_01,
    7'b00_1_01_00, 7'b00_1_00_00,
    // R3 x4 forward, reverse, R6 illegal
    7'b11_0_10_10, 7'b11_0_11_10, 7'b11_0_01_10, 7'b11_0_00_10,
    7'b11_0_01_01, 7'b11_0_11_01, 7'b11_0_00_00,
    // R4 x2
    7'b10_0_10_10, 7'b10_0_11_00, 7'b10_0_01_10, 7'b10_0_00_00,
    // R5 x1
    7'b01_0_10_10, 7'b01_0_11_00, 7'b01_0_01_00, 7'b01_0_00_00,
    7'b01_0_01_00, 7'b01_0_11_01, 7'b01_0_10_00, 7'b01_0_00_00
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive pins at a falling edge; return inside the cycle where the event shows
  task automatic pins(input logic a, input logic b, input logic g);
    @(negedge clk);
    pin_a = a; pin_b = b; pin_g = g;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R13 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 up", cnt_up, 1'b0);
    check("R13 dn", cnt_dn, 1'b0);
    check("R13 dir", dir_up, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R13 up after", cnt_up, 1'b0);

    // Vector walk for R1..R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      quad_sel = VEC[i][6:5];
      dir_mode = VEC[i][4];
      pins(VEC[i][3], VEC[i][2], 1'b0);
      check($sformatf("R1-6 vec%0d up", i), cnt_up, VEC[i][1]);
      check($sformatf("R1-6 vec%0d dn", i), cnt_dn, VEC[i][0]);
    end

    @(negedge clk);
    quad_sel = 2'd0; dir_mode = 1'b0;

    // R7 enable off
    in_enable = 1'b0;
    pins(1'b1, 1'b0, 1'b0);
    check("R7 blocked", cnt_up, 1'b0);
    pins(1'b0, 1'b0, 1'b0);
    in_enable = 1'b1;

    // R8 gate pin
    pins(1'b0, 1'b0, 1'b1);
    pins(1'b1, 1'b0, 1'b1);
    check("R8 gate high blocks", cnt_up, 1'b0);
    pins(1'b0, 1'b0, 1'b0);
    pins(1'b1, 1'b0, 1'b0);
    check("R8 gate low counts", cnt_up, 1'b1);
    pins(1'b0, 1'b0, 1'b0);

    // R9 clear request
    check("R9 no clear in gate mode", ctr_clear, 1'b0);
    g_is_gate = 1'b0;
    #2 check("R9 clear asserted", ctr_clear, 1'b1);
    pins(1'b0, 1'b0, 1'b1);
    check("R9 clear released", ctr_clear, 1'b0);
    g_is_gate = 1'b1;
    pins(1'b0, 1'b0, 1'b0);

    // R10 steps bypass enable
    in_enable = 1'b0;
    step_up = 1'b1;
    #2 check("R10 step up", cnt_up, 1'b1);
    check("R10 step up dn", cnt_dn, 1'b0);
    @(negedge clk);
    step_up = 1'b0; step_dn = 1'b1;
    #2 check("R10 step dn", cnt_dn, 1'b1);
    // R11 both steps cancel
    step_up = 1'b1;
    #2 check("R11 both up", cnt_up, 1'b0);
    check("R11 both dn", cnt_dn, 1'b0);
    @(negedge clk);
    step_up = 1'b0; step_dn = 1'b0;
    in_enable = 1'b1;

    // R11 pin up event against step down
    pins(1'b1, 1'b0, 1'b0);
    step_dn = 1'b1;
    #2 check("R11 cancel up", cnt_up, 1'b0);
    check("R11 cancel dn", cnt_dn, 1'b0);
    step_dn = 1'b0;
    pins(1'b0, 1'b0, 1'b0);

    // R12 direction status
    @(negedge clk);
    quad_sel = 2'd3;
    pins(1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R12 dir down", dir_up, 1'b0);
    pins(1'b0, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R12 dir up", dir_up, 1'b1);
    pins(1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R12 dir down again", dir_up, 1'b0);
    quad_sel = 2'd0;
    #2 check("R12 forced high", dir_up, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule